// File: doc/BRIEF.md
# Processor Standby Clock-Gating Controller

This block follows one processor core through its two idle flavours, wait-for-interrupt (WFI) and wait-for-event (WFE), and drives the enable of that core's gated clock. An entry request first waits until the pipeline has drained. For WFE it also waits until earlier explicit memory accesses have finished. Only then does the core count as idle: the clock enable drops and the matching standby flag rises. A high standby flag is the promise to the outside that the core is idle.

While the core is idle, three kinds of traffic can switch the clock back on without ending idle: a coherency snoop that needs the L1 data cache, an APB access to debug or trace registers, and an AXI TCM slave access. Each kind has a request and a done strobe. The clock stays on from the request until the done strobe, then for a configurable number of extra cycles. The standby flag stays high during this time. The two idle flavours end on different conditions. When idle ends, the clock enable rises in the same cycle and the flag falls one cycle later.

Top module: `stby_clk_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `clk_en_o` is 1 and both standby flags are 0.
- R2: After a WFI request, the core stays in a pending state with the clock on until `drained_i` is sampled high. `standby_wfi_o` rises on the cycle after that sample, and `clk_en_o` drops in that same cycle unless traffic or an exit is present.
- R3: After a WFE request, idle is entered only once `drained_i` and `mem_idle_i` are sampled high in the same cycle. `standby_wfe_o` rises on the next cycle.
- R4: Whenever neither standby flag is high, `clk_en_o` is 1.
- R5: While idle, a request on `svc_req_i` (bit 0 snoop, bit 1 debug, bit 2 TCM) makes `clk_en_o` high from the request cycle through the cycle of the matching `svc_done_i` bit, plus TAIL_CYC more cycles, after which it returns to 0. The standby flag stays high throughout, except for the TCM request that R7 names as a WFE exit.
- R6: WFI idle ends on `irq_wake_i` or `bcast_i`: `clk_en_o` is 1 in that cycle and `standby_wfi_o` is 0 on the next. `event_i` has no effect on WFI idle.
- R7: WFE idle ends on `irq_wake_i`, `bcast_i`, `event_i` or `svc_req_i[2]` (TCM). `clk_en_o` is 1 in that cycle and `standby_wfe_o` is 0 on the next.
- R8: An exit condition of the requested flavour that arrives while entry is still pending cancels the entry, even in the cycle where the drain conditions are met. The core returns to run and no standby flag rises.
- R9: If WFI and WFE requests arrive in the same cycle, WFI is taken. Entry requests made while the core is idle are ignored.
- R10: `standby_wfi_o` and `standby_wfe_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wfi_req_i | input | 1 | Request to enter WFI idle (pulse) |
| wfe_req_i | input | 1 | Request to enter WFE idle (pulse) |
| drained_i | input | 1 | All earlier instructions have completed |
| mem_idle_i | input | 1 | All earlier explicit memory accesses have completed |
| svc_req_i | input | NSRC | Traffic request per source: 0 snoop, 1 debug, 2 TCM |
| svc_done_i | input | NSRC | Traffic completion strobe per source |
| event_i | input | 1 | Event input (WFE exit) |
| irq_wake_i | input | 1 | Architectural wake-up event |
| bcast_i | input | 1 | Broadcast maintenance operation strobe |
| clk_en_o | output | 1 | Enable for the core's gated clock |
| standby_wfi_o | output | 1 | Core is idle in WFI |
| standby_wfe_o | output | 1 | Core is idle in WFE |

## Verification
The bench builds the block with its default parameters: three traffic sources, the TCM source at index 2, and a one-cycle tail (TAIL_CYC = 1). With a one-cycle tail, the full hold window fits in a short directed sequence: request, wait, done, tail, drop. This makes the exact drop cycle of the enable checkable. Source index 2 makes the TCM request reachable both as a temporary wake in WFI and as an exit in WFE. This shows the difference between the two flavours on the same pin.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_PEND_WFI = 3'd1,
    ST_PEND_WFE = 3'd2,
    ST_IDLE_WFI = 3'd3,
    ST_IDLE_WFE = 3'd4
  } stby_state_e;

endpackage

// File: rtl/stby_hold.sv
// Temporary clock hold for one traffic source: active from request to done,
// then for TAIL_CYC further cycles.
module stby_hold #(
  parameter int TAIL_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic done_i,
  output logic active_o
);
  localparam int CW = (TAIL_CYC < 1) ? 1 : $clog2(TAIL_CYC + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] tail_q, tail_d;
  logic          open_c;

  assign open_c = busy_q | req_i;

  always_comb begin
    busy_d = open_c & ~done_i;
    tail_d = tail_q;
    if (open_c && done_i) begin
      tail_d = CW'(TAIL_CYC);
    end else if (tail_q != '0) begin
      tail_d = tail_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tail_q <= '0;
    end else begin
      busy_q <= busy_d;
      tail_q <= tail_d;
    end
  end

  assign active_o = open_c | (tail_q != '0);

endmodule

// File: rtl/stby_seq.sv
// Idle-state sequencer: entry after drain, flavour-specific exit decode.
module stby_seq
  import stby_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wfi_req_i,
  input  logic wfe_req_i,
  input  logic drained_i,
  input  logic mem_idle_i,
  input  logic irq_wake_i,
  input  logic bcast_i,
  input  logic event_i,
  input  logic tcm_req_i,
  output logic in_idle_o,
  output logic wake_now_o,
  output logic idle_wfi_o,
  output logic idle_wfe_o
);
  stby_state_e state_q, state_d;
  logic        wfi_exit_c, wfe_exit_c;

  assign wfi_exit_c = irq_wake_i | bcast_i;
  assign wfe_exit_c = wfi_exit_c | event_i | tcm_req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (wfi_req_i)      state_d = ST_PEND_WFI;
        else if (wfe_req_i) state_d = ST_PEND_WFE;
      end
      ST_PEND_WFI: begin
        if (wfi_exit_c)     state_d = ST_RUN;
        else if (drained_i) state_d = ST_IDLE_WFI;
      end
      ST_PEND_WFE: begin
        if (wfe_exit_c)                   state_d = ST_RUN;
        else if (drained_i && mem_idle_i) state_d = ST_IDLE_WFE;
      end
      ST_IDLE_WFI: if (wfi_exit_c) state_d = ST_RUN;
      ST_IDLE_WFE: if (wfe_exit_c) state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign idle_wfi_o = (state_q == ST_IDLE_WFI);
  assign idle_wfe_o = (state_q == ST_IDLE_WFE);
  assign in_idle_o  = idle_wfi_o | idle_wfe_o;
  assign wake_now_o = (idle_wfi_o & wfi_exit_c) | (idle_wfe_o & wfe_exit_c);

endmodule

// File: rtl/stby_clk_ctrl.sv
// Standby clock-gating controller for one core.
module stby_clk_ctrl #(
  parameter int NSRC     = 3,
  parameter int TCM_IDX  = 2,
  parameter int TAIL_CYC = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wfi_req_i,
  input  logic            wfe_req_i,
  input  logic            drained_i,
  input  logic            mem_idle_i,
  input  logic [NSRC-1:0] svc_req_i,
  input  logic [NSRC-1:0] svc_done_i,
  input  logic            event_i,
  input  logic            irq_wake_i,
  input  logic            bcast_i,
  output logic            clk_en_o,
  output logic            standby_wfi_o,
  output logic            standby_wfe_o
);
  logic [NSRC-1:0] svc_act;
  logic            in_idle, wake_now;

  for (genvar g = 0; g < NSRC; g++) begin : g_hold
    stby_hold #(.TAIL_CYC(TAIL_CYC)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (svc_req_i[g]),
      .done_i   (svc_done_i[g]),
      .active_o (svc_act[g])
    );
  end

  stby_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wfi_req_i  (wfi_req_i),
    .wfe_req_i  (wfe_req_i),
    .drained_i  (drained_i),
    .mem_idle_i (mem_idle_i),
    .irq_wake_i (irq_wake_i),
    .bcast_i    (bcast_i),
    .event_i    (event_i),
    .tcm_req_i  (svc_req_i[TCM_IDX]),
    .in_idle_o  (in_idle),
    .wake_now_o (wake_now),
    .idle_wfi_o (standby_wfi_o),
    .idle_wfe_o (standby_wfe_o)
  );

  assign clk_en_o = ~in_idle | wake_now | (|svc_act);

endmodule

// File: rtl/stby_clk_ctrl_chk.sv
module stby_clk_ctrl_chk #(
  parameter int NSRC    = 3,
  parameter int TCM_IDX = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            drained_i,
  input logic            mem_idle_i,
  input logic [NSRC-1:0] svc_req_i,
  input logic            event_i,
  input logic            irq_wake_i,
  input logic            bcast_i,
  input logic            clk_en_o,
  input logic            standby_wfi_o,
  input logic            standby_wfe_o
);
  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(standby_wfi_o && standby_wfe_o));

  // R2
  wfi_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby_wfi_o) |-> $past(drained_i));

  // R3
  wfe_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby_wfe_o) |-> $past(drained_i && mem_idle_i));

  // R4
  run_clk_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_wfi_o && !standby_wfe_o) |-> clk_en_o);

  // R5
  svc_clk_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((standby_wfi_o || standby_wfe_o) && (|svc_req_i)) |-> clk_en_o);

  // R5
  wfi_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_wfi_o && !irq_wake_i && !bcast_i) |=> standby_wfi_o);

  // R6
  wfi_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_wfi_o && (irq_wake_i || bcast_i)) |=> !standby_wfi_o);

  // R6
  wfi_exit_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_wfi_o && (irq_wake_i || bcast_i)) |-> clk_en_o);

  // R7
  wfe_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_wfe_o && (event_i || svc_req_i[TCM_IDX] || irq_wake_i || bcast_i))
      |=> !standby_wfe_o);

endmodule

bind stby_clk_ctrl stby_clk_ctrl_chk #(.NSRC(NSRC), .TCM_IDX(TCM_IDX)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .drained_i     (drained_i),
  .mem_idle_i    (mem_idle_i),
  .svc_req_i     (svc_req_i),
  .event_i       (event_i),
  .irq_wake_i    (irq_wake_i),
  .bcast_i       (bcast_i),
  .clk_en_o      (clk_en_o),
  .standby_wfi_o (standby_wfi_o),
  .standby_wfe_o (standby_wfe_o)
);

// File: tb/stby_clk_ctrl_test.sv
`timescale 1ns/1ps
module stby_clk_ctrl_test;
  localparam int NSRC = 3;

  logic            clk;
  logic            rst_n;
  logic            wfi_req_i, wfe_req_i, drained_i, mem_idle_i;
  logic [NSRC-1:0] svc_req_i, svc_done_i;
  logic            event_i, irq_wake_i, bcast_i;
  logic            clk_en_o, standby_wfi_o, standby_wfe_o;

  int checks = 0;
  int errors = 0;

  stby_clk_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .wfi_req_i(wfi_req_i), .wfe_req_i(wfe_req_i),
    .drained_i(drained_i), .mem_idle_i(mem_idle_i),
    .svc_req_i(svc_req_i), .svc_done_i(svc_done_i),
    .event_i(event_i), .irq_wake_i(irq_wake_i), .bcast_i(bcast_i),
    .clk_en_o(clk_en_o), .standby_wfi_o(standby_wfi_o),
    .standby_wfe_o(standby_wfe_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic clr();
    wfi_req_i = 0; wfe_req_i = 0; drained_i = 0; mem_idle_i = 0;
    svc_req_i = '0; svc_done_i = '0;
    event_i = 0; irq_wake_i = 0; bcast_i = 0;
  endtask

  // Move to the next drive point: inputs take new values right after here.
  task automatic nxt();
    @(negedge clk);
    clr();
  endtask

  // Check outputs 1 ns after inputs were driven.
  task automatic chk(input string tag, input logic en, input logic wi, input logic we);
    #1;
    checks++;
    if (clk_en_o !== en || standby_wfi_o !== wi || standby_wfe_o !== we) begin
      errors++;
      $display("FAIL %s: actual en=%b wfi=%b wfe=%b expected en=%b wfi=%b wfe=%b",
               tag, clk_en_o, standby_wfi_o, standby_wfe_o, en, wi, we);
    end
    checks++;
    if (standby_wfi_o && standby_wfe_o) begin
      errors++;
      $display("FAIL R10: actual wfi=1 wfe=1 expected not both");
    end
  endtask

  task automatic go_wfi();
    nxt(); wfi_req_i = 1;               chk("R4 wfi request", 1, 0, 0);
    nxt(); drained_i = 1;               chk("R2 drain seen", 1, 0, 0);
    nxt();                              chk("R2 wfi idle", 0, 1, 0);
  endtask

  task automatic go_wfe();
    nxt(); wfe_req_i = 1;               chk("R4 wfe request", 1, 0, 0);
    nxt(); drained_i = 1;               chk("R3 no mem idle", 1, 0, 0);
    nxt(); drained_i = 1; mem_idle_i = 1; chk("R3 both seen", 1, 0, 0);
    nxt();                              chk("R3 wfe idle", 0, 0, 1);
  endtask

  task automatic t_reset();
    clr();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1, 0, 0);
    rst_n = 1;
    nxt();                              chk("R1 after release", 1, 0, 0);
  endtask

  task automatic t_wfi();
    nxt(); wfi_req_i = 1;               chk("R4 request", 1, 0, 0);
    nxt();                              chk("R2 pending", 1, 0, 0);
    nxt();                              chk("R2 pending", 1, 0, 0);
    nxt(); drained_i = 1;               chk("R2 drain", 1, 0, 0);
    nxt();                              chk("R2 idle", 0, 1, 0);
    nxt(); event_i = 1;                 chk("R6 event ignored", 0, 1, 0);
    nxt();                              chk("R6 still idle", 0, 1, 0);
    nxt(); wfe_req_i = 1;               chk("R9 request in idle", 0, 1, 0);
    nxt();                              chk("R9 ignored", 0, 1, 0);
    nxt(); irq_wake_i = 1;              chk("R6 irq wake", 1, 1, 0);
    nxt();                              chk("R6 flag low", 1, 0, 0);
    go_wfi();
    nxt(); bcast_i = 1;                 chk("R6 bcast wake", 1, 1, 0);
    nxt();                              chk("R6 flag low", 1, 0, 0);
  endtask

  task automatic t_traffic();
    go_wfi();
    nxt(); svc_req_i = 3'b001;          chk("R5 snoop req", 1, 1, 0);
    nxt();                              chk("R5 busy", 1, 1, 0);
    nxt();                              chk("R5 busy", 1, 1, 0);
    nxt(); svc_done_i = 3'b001;         chk("R5 done", 1, 1, 0);
    nxt();                              chk("R5 tail", 1, 1, 0);
    nxt();                              chk("R5 dropped", 0, 1, 0);
    nxt(); svc_req_i = 3'b100; svc_done_i = 3'b100; chk("R5 tcm in wfi", 1, 1, 0);
    nxt();                              chk("R5 tcm tail", 1, 1, 0);
    nxt();                              chk("R5 tcm dropped", 0, 1, 0);
    nxt(); svc_req_i = 3'b010;          chk("R5 debug req", 1, 1, 0);
    nxt(); svc_done_i = 3'b010;         chk("R5 debug done", 1, 1, 0);
    nxt();                              chk("R5 debug tail", 1, 1, 0);
    nxt();                              chk("R5 debug dropped", 0, 1, 0);
    nxt(); irq_wake_i = 1;              chk("R6 wake", 1, 1, 0);
    nxt();                              chk("R6 run", 1, 0, 0);
  endtask

  task automatic t_wfe();
    go_wfe();
    nxt(); event_i = 1;                 chk("R7 event", 1, 0, 1);
    nxt();                              chk("R7 flag low", 1, 0, 0);
    go_wfe();
    nxt(); svc_req_i = 3'b100;          chk("R7 tcm exit", 1, 0, 1);
    nxt(); svc_done_i = 3'b100;         chk("R7 flag low", 1, 0, 0);
    nxt();                              chk("R7 run", 1, 0, 0);
    go_wfe();
    nxt(); svc_req_i = 3'b001; svc_done_i = 3'b001; chk("R5 snoop in wfe", 1, 0, 1);
    nxt();                              chk("R5 tail in wfe", 1, 0, 1);
    nxt();                              chk("R5 dropped in wfe", 0, 0, 1);
    nxt(); irq_wake_i = 1;              chk("R7 irq", 1, 0, 1);
    nxt();                              chk("R7 flag low", 1, 0, 0);
    go_wfe();
    nxt(); bcast_i = 1;                 chk("R7 bcast", 1, 0, 1);
    nxt();                              chk("R7 flag low", 1, 0, 0);
  endtask

  task automatic t_abort();
    nxt(); wfi_req_i = 1;               chk("R8 wfi req", 1, 0, 0);
    nxt(); irq_wake_i = 1; drained_i = 1; chk("R8 abort wfi", 1, 0, 0);
    nxt(); drained_i = 1;               chk("R8 back in run", 1, 0, 0);
    nxt();                              chk("R8 no flag", 1, 0, 0);
    nxt(); wfe_req_i = 1;               chk("R8 wfe req", 1, 0, 0);
    nxt(); event_i = 1; drained_i = 1; mem_idle_i = 1; chk("R8 abort wfe", 1, 0, 0);
    nxt(); drained_i = 1; mem_idle_i = 1; chk("R8 back in run", 1, 0, 0);
    nxt();                              chk("R8 no flag", 1, 0, 0);
  endtask

  task automatic t_priority();
    nxt(); wfi_req_i = 1; wfe_req_i = 1; chk("R9 both req", 1, 0, 0);
    nxt(); drained_i = 1; mem_idle_i = 1; chk("R9 drain", 1, 0, 0);
    nxt();                              chk("R9 wfi chosen", 0, 1, 0);
    nxt(); irq_wake_i = 1;              chk("R6 wake", 1, 1, 0);
    nxt();                              chk("R6 run", 1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_wfi();
    t_traffic();
    t_wfe();
    t_abort();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule